// File: doc/BRIEF.md
# Adaptive Half-Bridge Gate Sequencer

This block is the digital sequencing core for one synchronous buck half-bridge. A PWM command comes in already split into three one-hot level flags (high, low, mid-level window). Alongside it come an active-low disable, an active-low skip-mode input, a supply-good flag and two comparator flags. One comparator says the low-side gate has dropped below its threshold. The other says the switch node has dropped below its threshold. From these the block produces registered enables for the high-side and low-side gate drivers.

Turn-on is break-before-make. When the command moves to high, the low-side gate is released first. The high-side gate is enabled only after the low-side gate comparator has read low for a dead-on count of consecutive cycles. When the command moves to low, the high-side gate is released first. The low-side gate then waits for the switch-node comparator to read low for a dead-off count of consecutive cycles. If the switch node never reports low, a fallback timeout enables the low-side gate anyway.

A mid-level command shuts both gates off, but only once it has persisted for a hold-off count. A shorter excursion leaves the last valid level in force. Skip mode keeps the low-side gate off, which gives diode emulation at light load. All delays are parameters in clock cycles.

Top module: `hbs_gate_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first turn-on completes, both hs_en and ls_en are 0.
- R2: When supply_ok is 0 or dis_n is 0 at a clock edge, both outputs are 0 after that edge, whatever the PWM flags.
- R3: The flags pwm_hi, pwm_lo and pwm_mid are one-hot. If pwm_mid is sampled high on HOLDOFF_CYC consecutive edges, both outputs are 0 from the next edge onward, for as long as pwm_mid stays high. A run shorter than HOLDOFF_CYC does not change the outputs.
- R4: After a qualified mid-level period ends, the block follows the new flag. With pwm_hi it turns on hs_en only, and with pwm_lo it turns on ls_en only, each through its normal dead-time wait.
- R5: With skip_n at 1 and the block enabled, a settled level of 1 gives hs_en=1 and ls_en=0. A settled level of 0 gives hs_en=0 and ls_en=1.
- R6: While skip_n is 0, ls_en stays 0 from the next edge onward. hs_en still follows level 1.
- R7: On a move to level 1, ls_en drops at the first edge. hs_en rises on the DEADON_CYC-th consecutive edge at which ls_gate_low is sampled 1.
- R8: On a move to level 0, hs_en drops at the first edge. ls_en rises on the DEADOFF_CYC-th consecutive edge at which sw_low is sampled 1.
- R9: If sw_low stays 0, ls_en rises TIMEOUT_CYC edges after the edge at which hs_en dropped.
- R10: hs_en and ls_en are never 1 in the same cycle.
- R11: A level change during a dead-time wait abandons that wait and starts the wait for the new level with cleared counts.
- R12: While pwm_mid is high but not yet qualified, the last valid level (from pwm_hi or pwm_lo) stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Bias supply good, high to allow switching |
| dis_n | input | 1 | Active-low disable of both gates |
| skip_n | input | 1 | Active-low skip mode; low keeps the low-side gate off |
| pwm_hi | input | 1 | PWM decoded as high level |
| pwm_lo | input | 1 | PWM decoded as low level |
| pwm_mid | input | 1 | PWM inside the mid-level window |
| ls_gate_low | input | 1 | Comparator: low-side gate below threshold |
| sw_low | input | 1 | Comparator: switch node below threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Directed sequences measure edge counts in several situations: rising and falling transitions with the comparators settled, a falling transition with the switch-node comparator stuck high (this separates the adaptive dead-off path from the timeout path), and mid-level runs one cycle short of and one cycle past the hold-off (this separates a glitch from a qualified shutdown). Level reversals in the middle of a wait show whether the wait restarts or keeps a stale count. Skip and disable toggles are applied while each gate is on. A long random run then mixes levels, comparator noise, disable, supply drops and skip changes, and checks every cycle against a bench model built from the requirements.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT_HS = 3'd1,
      ST_HS      = 3'd2,
      ST_WAIT_LS = 3'd3,
      ST_LS      = 3'd4
   } hbs_state_e;
endpackage

// File: rtl/hbs_mid_qual.sv
// Qualifies the mid-level flag: output rises after HOLDOFF consecutive high samples.
module hbs_mid_qual #(
   parameter int HOLDOFF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mid_i,
   output logic qual_o
);
   localparam int CW = $clog2(HOLDOFF + 1);

   if (HOLDOFF < 1) begin : g_bad_holdoff
      $error("hbs_mid_qual: HOLDOFF must be at least 1");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         qual_o <= 1'b0;
      end else if (!mid_i) begin
         run_q  <= '0;
         qual_o <= 1'b0;
      end else if (run_q == CW'(HOLDOFF - 1)) begin
         qual_o <= 1'b1;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/hbs_level_hold.sv
// Resolves the current PWM level; keeps the last valid level when neither flag is set.
module hbs_level_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_i,
   input  logic lo_i,
   output logic lvl_o
);
   logic held_q;

   always_comb begin
      if (hi_i)      lvl_o = 1'b1;
      else if (lo_i) lvl_o = 1'b0;
      else           lvl_o = held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= lvl_o;
   end
endmodule

// File: rtl/hbs_wait_cnt.sv
// Wait counter: hit_o marks the edge at which the LIMIT-th qualifying sample arrives.
module hbs_wait_cnt #(
   parameter int LIMIT       = 2,
   parameter bit CONSECUTIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic cond_i,
   output logic hit_o
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("hbs_wait_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic          at_top;

   assign at_top = (cnt_q == CW'(LIMIT - 1));
   assign hit_o  = cond_i && at_top;

   if (CONSECUTIVE) begin : g_consec
      always_comb begin
         if (clr_i || !cond_i)        cnt_d = '0;
         else if (cnt_q == CW'(LIMIT)) cnt_d = cnt_q;
         else                          cnt_d = cnt_q + 1'b1;
      end
   end else begin : g_cumul
      always_comb begin
         if (clr_i)                              cnt_d = '0;
         else if (!cond_i || cnt_q == CW'(LIMIT)) cnt_d = cnt_q;
         else                                    cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/hbs_gate_seq.sv
module hbs_gate_seq #(
   parameter int HOLDOFF_CYC = 4,
   parameter int DEADON_CYC  = 2,
   parameter int DEADOFF_CYC = 2,
   parameter int TIMEOUT_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic dis_n,
   input  logic skip_n,
   input  logic pwm_hi,
   input  logic pwm_lo,
   input  logic pwm_mid,
   input  logic ls_gate_low,
   input  logic sw_low,
   output logic hs_en,
   output logic ls_en
);
   import hbs_pkg::*;

   if (TIMEOUT_CYC <= DEADOFF_CYC) begin : g_bad_timeout
      $error("hbs_gate_seq: TIMEOUT_CYC must exceed DEADOFF_CYC");
   end

   hbs_state_e st_q, st_d;
   logic mid_q, lvl, en, want_hs, want_ls;
   logic on_hit, off_hit, tmo_hit;

   hbs_mid_qual #(.HOLDOFF(HOLDOFF_CYC)) u_mid (
      .clk(clk), .rst_n(rst_n), .mid_i(pwm_mid), .qual_o(mid_q));

   hbs_level_hold u_lvl (
      .clk(clk), .rst_n(rst_n), .hi_i(pwm_hi), .lo_i(pwm_lo), .lvl_o(lvl));

   hbs_wait_cnt #(.LIMIT(DEADON_CYC), .CONSECUTIVE(1'b1)) u_on_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(st_q != ST_WAIT_HS),
      .cond_i(ls_gate_low), .hit_o(on_hit));

   hbs_wait_cnt #(.LIMIT(DEADOFF_CYC), .CONSECUTIVE(1'b1)) u_off_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(st_q != ST_WAIT_LS),
      .cond_i(sw_low), .hit_o(off_hit));

   hbs_wait_cnt #(.LIMIT(TIMEOUT_CYC), .CONSECUTIVE(1'b1)) u_tmo_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(st_q != ST_WAIT_LS),
      .cond_i(1'b1), .hit_o(tmo_hit));

   assign en      = supply_ok && dis_n && !mid_q;
   assign want_hs = en && lvl;
   assign want_ls = en && !lvl && skip_n;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (want_hs)      st_d = ST_WAIT_HS;
            else if (want_ls) st_d = ST_WAIT_LS;
         end
         ST_WAIT_HS: begin
            if (!want_hs)    st_d = want_ls ? ST_WAIT_LS : ST_IDLE;
            else if (on_hit) st_d = ST_HS;
         end
         ST_HS: begin
            if (!want_hs) st_d = want_ls ? ST_WAIT_LS : ST_IDLE;
         end
         ST_WAIT_LS: begin
            if (!want_ls)               st_d = want_hs ? ST_WAIT_HS : ST_IDLE;
            else if (off_hit || tmo_hit) st_d = ST_LS;
         end
         ST_LS: begin
            if (!want_ls) st_d = want_hs ? ST_WAIT_HS : ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         hs_en <= 1'b0;
         ls_en <= 1'b0;
      end else begin
         st_q  <= st_d;
         hs_en <= (st_d == ST_HS);
         ls_en <= (st_d == ST_LS);
      end
   end
endmodule

// File: rtl/hbs_gate_seq_chk.sv
module hbs_gate_seq_chk #(
   parameter int HOLDOFF_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic supply_ok,
   input logic dis_n,
   input logic skip_n,
   input logic pwm_mid,
   input logic ls_gate_low,
   input logic sw_low,
   input logic hs_en,
   input logic ls_en
);
   localparam int MW = $clog2(HOLDOFF_CYC + 2);
   logic [MW-1:0] mid_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mid_run_q <= '0;
      else if (!pwm_mid)                      mid_run_q <= '0;
      else if (mid_run_q != MW'(HOLDOFF_CYC + 1)) mid_run_q <= mid_run_q + 1'b1;
   end

   a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!dis_n || !supply_ok) |=> (!hs_en && !ls_en));

   a_r6_skip_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
      !skip_n |=> !ls_en);

   a_r7_hs_after_ls_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> ($past(ls_gate_low) && !$past(ls_en)));

   a_r8_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> !$past(hs_en));

   a_r3_mid_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_run_q == MW'(HOLDOFF_CYC + 1)) |-> (!hs_en && !ls_en));

   // sw_low feeds only the dead-off path; referenced so every port is used
   a_r8_sw_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(sw_low));
endmodule

bind hbs_gate_seq hbs_gate_seq_chk #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dis_n(dis_n),
   .skip_n(skip_n), .pwm_mid(pwm_mid), .ls_gate_low(ls_gate_low),
   .sw_low(sw_low), .hs_en(hs_en), .ls_en(ls_en));

// File: tb/hbs_gate_seq_tb.sv
module hbs_gate_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HOLDOFF = 4;
   localparam int DEADON  = 2;
   localparam int DEADOFF = 2;
   localparam int TIMEOUT = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b1, dis_n = 1'b1, skip_n = 1'b1;
   logic pwm_hi = 1'b0, pwm_lo = 1'b1, pwm_mid = 1'b0;
   logic ls_gate_low = 1'b1, sw_low = 1'b1;
   logic hs_en, ls_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbs_gate_seq #(.HOLDOFF_CYC(HOLDOFF), .DEADON_CYC(DEADON),
                  .DEADOFF_CYC(DEADOFF), .TIMEOUT_CYC(TIMEOUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dis_n(dis_n),
      .skip_n(skip_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm_mid(pwm_mid),
      .ls_gate_low(ls_gate_low), .sw_low(sw_low), .hs_en(hs_en), .ls_en(ls_en));

   // ---------------- reference model built from the requirements ----------
   int  m_phase;            // 0 off, 1 waiting for hs, 2 hs, 3 waiting for ls, 4 ls
   int  m_on_run, m_off_run, m_since_hs_off, m_mid_run;
   bit  m_last_lvl;
   bit  exp_hs, exp_ls;

   function automatic bit lvl_now(bit hi, bit lo, bit last);
      return hi ? 1'b1 : (lo ? 1'b0 : last);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_on_run = 0; m_off_run = 0; m_since_hs_off = 0;
         m_mid_run = 0; m_last_lvl = 1'b0; exp_hs = 1'b0; exp_ls = 1'b0;
      end else begin
         bit l, act, whs, wls, on_ok, off_ok;
         int nxt;
         l   = lvl_now(pwm_hi, pwm_lo, m_last_lvl);
         act = supply_ok && dis_n && (m_mid_run < HOLDOFF);
         whs = act && l;
         wls = act && !l && skip_n;
         on_ok  = ls_gate_low && (m_on_run + 1 >= DEADON);
         off_ok = (sw_low && (m_off_run + 1 >= DEADOFF)) || (m_since_hs_off + 1 >= TIMEOUT);
         nxt = m_phase;
         case (m_phase)
            0: nxt = whs ? 1 : (wls ? 3 : 0);
            1: nxt = !whs ? (wls ? 3 : 0) : (on_ok ? 2 : 1);
            2: nxt = !whs ? (wls ? 3 : 0) : 2;
            3: nxt = !wls ? (whs ? 1 : 0) : (off_ok ? 4 : 3);
            default: nxt = !wls ? (whs ? 1 : 0) : 4;
         endcase
         m_on_run       = (m_phase == 1 && ls_gate_low) ? m_on_run + 1 : 0;
         m_off_run      = (m_phase == 3 && sw_low) ? m_off_run + 1 : 0;
         m_since_hs_off = (m_phase == 3) ? m_since_hs_off + 1 : 0;
         m_mid_run      = pwm_mid ? ((m_mid_run < HOLDOFF) ? m_mid_run + 1 : m_mid_run) : 0;
         m_last_lvl     = l;
         m_phase        = nxt;
         exp_hs = (nxt == 2);
         exp_ls = (nxt == 4);
      end
   end

   // ---------------- checking helpers -------------------------------------
   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   bit    cmp_on = 1'b0;
   string cur_tag = "R5 model";

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check_bit({cur_tag, " hs_en"}, hs_en, exp_hs);
         check_bit({cur_tag, " ls_en"}, ls_en, exp_ls);
         check_bit("R10 exclusive", hs_en && ls_en, 1'b0);
      end
   end

   task automatic set_lvl(input int code); // 0 low, 1 high, 2 mid
      pwm_hi  = (code == 1);
      pwm_lo  = (code == 0);
      pwm_mid = (code == 2);
   endtask

   task automatic edges_until_hs(output int n);
      n = 0;
      while (hs_en !== 1'b1 && n < 100) begin @(negedge clk); n++; end
   endtask

   task automatic edges_until_ls(output int n);
      n = 0;
      while (ls_en !== 1'b1 && n < 100) begin @(negedge clk); n++; end
   endtask

   // ---------------- watchdog ---------------------------------------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ---------------------------------------------
   initial begin
      int n;
      bit ls_seen, hs_seen;
      void'($urandom(32'd20240611));

      // R1: reset state
      repeat (3) @(negedge clk);
      check_bit("R1 reset hs_en", hs_en, 1'b0);
      check_bit("R1 reset ls_en", ls_en, 1'b0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      check_bit("R1 first edge hs_en", hs_en, 1'b0);
      check_bit("R1 first edge ls_en", ls_en, 1'b0);
      edges_until_ls(n);
      check_bit("R5 level 0 gives ls", ls_en, 1'b1);

      // R7: rising transition
      cur_tag = "R7 model";
      @(negedge clk); set_lvl(1);
      @(negedge clk);
      check_bit("R7 ls drops first", ls_en, 1'b0);
      check_bit("R7 hs not yet", hs_en, 1'b0);
      edges_until_hs(n);
      check_int("R7 dead-on edges", n, DEADON);

      // R8: falling transition, switch node reports low
      cur_tag = "R8 model";
      set_lvl(0);
      @(negedge clk);
      check_bit("R8 hs drops first", hs_en, 1'b0);
      edges_until_ls(n);
      check_int("R8 dead-off edges", n, DEADOFF);

      // R9: switch node comparator stuck
      cur_tag = "R9 model";
      set_lvl(1); edges_until_hs(n);
      sw_low = 1'b0; set_lvl(0);
      @(negedge clk);
      check_bit("R9 hs dropped", hs_en, 1'b0);
      edges_until_ls(n);
      check_int("R9 timeout edges", n, TIMEOUT);
      sw_low = 1'b1;

      // R6: skip mode
      cur_tag = "R6 model";
      skip_n = 1'b0;
      @(negedge clk);
      check_bit("R6 ls off under skip", ls_en, 1'b0);
      set_lvl(1); edges_until_hs(n);
      check_bit("R6 hs follows high", hs_en, 1'b1);
      set_lvl(0);
      ls_seen = 1'b0;
      repeat (3*TIMEOUT) begin @(negedge clk); if (ls_en) ls_seen = 1'b1; end
      check_bit("R6 ls stays off", ls_seen, 1'b0);
      skip_n = 1'b1;
      edges_until_ls(n);

      // R3 / R12: short mid-level excursion while hs on
      cur_tag = "R12 model";
      set_lvl(1); edges_until_hs(n);
      set_lvl(2);
      hs_seen = 1'b1;
      repeat (HOLDOFF-1) begin @(negedge clk); if (!hs_en) hs_seen = 1'b0; end
      set_lvl(1);
      repeat (3) begin @(negedge clk); if (!hs_en) hs_seen = 1'b0; end
      check_bit("R12 short mid keeps hs", hs_seen, 1'b1);

      // R3: qualified mid-level
      cur_tag = "R3 model";
      set_lvl(2);
      repeat (HOLDOFF) @(negedge clk);
      check_bit("R3 hs still on at hold-off", hs_en, 1'b1);
      @(negedge clk);
      check_bit("R3 hs off after hold-off", hs_en, 1'b0);
      check_bit("R3 ls off after hold-off", ls_en, 1'b0);
      repeat (5) @(negedge clk);

      // R4: exit mid-level to low, then via mid to high
      cur_tag = "R4 model";
      set_lvl(0);
      hs_seen = 1'b0; n = 0;
      while (!ls_en && n < 50) begin @(negedge clk); n++; if (hs_en) hs_seen = 1'b1; end
      check_bit("R4 exit to low gives ls", ls_en, 1'b1);
      check_bit("R4 exit to low no hs", hs_seen, 1'b0);
      set_lvl(2); repeat (HOLDOFF + 3) @(negedge clk);
      set_lvl(1);
      ls_seen = 1'b0; n = 0;
      while (!hs_en && n < 50) begin @(negedge clk); n++; if (ls_en) ls_seen = 1'b1; end
      check_bit("R4 exit to high gives hs", hs_en, 1'b1);
      check_bit("R4 exit to high no ls", ls_seen, 1'b0);

      // R2: disable and supply loss
      cur_tag = "R2 model";
      dis_n = 1'b0;
      @(negedge clk);
      check_bit("R2 disable hs", hs_en, 1'b0);
      set_lvl(0); repeat (TIMEOUT + 2) @(negedge clk);
      check_bit("R2 disable ls", ls_en, 1'b0);
      dis_n = 1'b1; edges_until_ls(n);
      supply_ok = 1'b0;
      @(negedge clk);
      check_bit("R2 supply loss ls", ls_en, 1'b0);
      set_lvl(1); repeat (4) @(negedge clk);
      check_bit("R2 supply loss hs", hs_en, 1'b0);
      supply_ok = 1'b1; edges_until_hs(n);

      // R11: reversal during waits
      cur_tag = "R11 model";
      sw_low = 1'b0; set_lvl(0);
      repeat (3) @(negedge clk);
      set_lvl(1);
      edges_until_hs(n);
      check_int("R11 restart toward hs", n, DEADON + 1);
      ls_gate_low = 1'b0; set_lvl(0);
      @(negedge clk); set_lvl(1);
      repeat (3) @(negedge clk);
      ls_gate_low = 1'b1;
      edges_until_hs(n);
      check_int("R11 dead-on restarts from zero", n, DEADON);
      sw_low = 1'b1;

      // random phase, model compared every cycle
      cur_tag = "R5 model";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         if ($urandom % 7 == 0) begin
            int r;
            r = $urandom % 10;
            set_lvl(r < 2 ? 2 : (r < 6 ? 1 : 0));
         end
         ls_gate_low = ($urandom % 4) != 0;
         sw_low      = ($urandom % 3) != 0;
         if ($urandom % 200 == 0) sw_low = 1'b0;
         dis_n       = ($urandom % 50) != 0;
         supply_ok   = ($urandom % 80) != 0;
         if ($urandom % 40 == 0) skip_n = ~skip_n;
      end

      @(negedge clk);
      cmp_on = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule